// File: doc/BRIEF.md
# CPU-Cycle Interrupt Up-Counter

This block is a 15-bit up-counter that advances once for every CPU cycle. It raises an interrupt request when the count reaches its top value. Software works directly on the live count through two byte-wide registers, so there is no reload latch. A read returns the current count. A write replaces the addressed count byte at once. The upper register also carries the enable bit. The counter runs only while that bit is set.

The block sits on the CPU side of a cartridge-style memory decoder. `cpu_ce` marks the single clock in each CPU cycle on which the bus is valid. `bus_sel` qualifies an access on that cycle. The register is selected by address bits 15:11:

- `5'b01010` (CPU range `$5000-$57FF`) selects the low count byte.
- `5'b01011` (CPU range `$5800-$5FFF`) selects the high byte and the enable bit.

The interrupt stays pending until software touches either register. A read or a write both count as the acknowledge.

Top module: `cyc_irq_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the count, the enable bit and the pending flag all become 0. After that edge, `rdata_lo`, `rdata_hi` and `irq` read 0.
- R2: The low register is selected when address bits 15:11 are `5'b01010`. A qualified write there loads count bits 7:0 from `wdata`. `rdata_lo` always shows count bits 7:0.
- R3: The high register is selected when address bits 15:11 are `5'b01011`. A qualified write there loads count bits 14:8 from `wdata[6:0]` and the enable from `wdata[7]`. `rdata_hi` always shows {enable, count bits 14:8}.
- R4: On each clock with `cpu_ce` high and enable 1, the count goes up by one. With `cpu_ce` low, or with enable 0, the count does not change.
- R5: The count stops at `15'h7FFF` and never wraps to 0.
- R6: The pending flag is set by the increment that takes the count to `15'h7FFF`. `irq` equals pending AND enable, updated on the same edge as the count.
- R7: Any qualified access clears the pending flag. This covers a read or a write of either register, with `cpu_ce` and `bus_sel` high. If the same cycle's increment reaches `15'h7FFF`, setting wins over the clear.
- R8: In a cycle that writes either count register, the counter does not also increment.
- R9: Some accesses change nothing. These are accesses with `bus_sel` low, accesses with `cpu_ce` low, and accesses whose address bits 15:11 match neither register. Such an access neither loads the count nor clears pending.
- R10: Loading `15'h7FFF` by writes does not set the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ce | input | 1 | One-clock strobe per CPU cycle |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| rdata_lo | output | 8 | Count bits 7:0 |
| rdata_hi | output | 8 | {enable, count bits 14:8} |
| irq | output | 1 | Active-high interrupt request |

## Verification
Several input patterns are run against the reference model:

- Free counting from 0 to the top value is timed exactly. This separates a correct terminal value from an off-by-one or a wrap.
- Bursts with `cpu_ce` low separate CPU-cycle counting from clock counting.
- A write that lands one cycle after an increment shows whether the write takes priority over the increment.
- An acknowledging read in the very cycle the top value is reached separates set-wins from clear-wins.
- Accesses to neighbouring pages, and unstrobed accesses, show whether the decode is tight.
- A long random mix of reads, writes and idles keeps the count near its top value. This exercises acknowledge and enable interplay that the directed cases miss.

// File: rtl/cic_pkg.sv
package cic_pkg;
  // Decoded, qualified request for one CPU cycle
  typedef struct packed {
    logic ack;    // any access to either register
    logic wr_lo;  // write to the low count byte
    logic wr_hi;  // write to the high byte / enable
  } cic_req_t;
endpackage

// File: rtl/cic_decode.sv
module cic_decode
  import cic_pkg::*;
#(
  parameter int PAGE_W = 5,
  parameter logic [PAGE_W-1:0] LO_PAGE = 5'b01010,
  parameter logic [PAGE_W-1:0] HI_PAGE = 5'b01011
) (
  input  logic              cpu_ce,
  input  logic              bus_sel,
  input  logic              bus_rnw,
  input  logic [PAGE_W-1:0] page,
  output cic_req_t          req
);
  logic hit_lo, hit_hi, live;

  assign live   = cpu_ce && bus_sel;
  assign hit_lo = live && (page == LO_PAGE);
  assign hit_hi = live && (page == HI_PAGE);

  always_comb begin
    req.ack   = hit_lo || hit_hi;
    req.wr_lo = hit_lo && !bus_rnw;
    req.wr_hi = hit_hi && !bus_rnw;
  end
endmodule

// File: rtl/cic_count.sv
module cic_count
  import cic_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_ce,
  input  cic_req_t          req,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  cnt,
  output logic              en,
  output logic              reach
);
  localparam int HI_W = CNT_W - DATA_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic any_wr, step;

  assign any_wr = req.wr_lo || req.wr_hi;
  assign step   = cpu_ce && en && !any_wr && (cnt != CNT_MAX);
  // the increment in this cycle lands on the top value
  assign reach  = step && (cnt == CNT_MAX - CNT_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      en  <= 1'b0;
    end else if (req.wr_lo) begin
      cnt[DATA_W-1:0] <= wdata;
    end else if (req.wr_hi) begin
      cnt[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
      en                  <= wdata[DATA_W-1];
    end else if (step) begin
      cnt <= cnt + CNT_ONE;
    end
  end
endmodule

// File: rtl/cic_flag.sv
module cic_flag (
  input  logic clk,
  input  logic rst,
  input  logic reach,
  input  logic ack,
  input  logic en,
  output logic irq
);
  logic pending;

  always_ff @(posedge clk) begin
    if (rst)        pending <= 1'b0;
    else if (reach) pending <= 1'b1;   // a new event beats an acknowledge
    else if (ack)   pending <= 1'b0;
  end

  assign irq = pending && en;
endmodule

// File: rtl/cyc_irq_counter.sv
module cyc_irq_counter
  import cic_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 15,
  parameter int PAGE_W = 5,
  parameter logic [PAGE_W-1:0] LO_PAGE = 5'b01010,
  parameter logic [PAGE_W-1:0] HI_PAGE = 5'b01011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_ce,
  input  logic              bus_sel,
  input  logic              bus_rnw,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_lo,
  output logic [DATA_W-1:0] rdata_hi,
  output logic              irq
);
  // high byte holds the enable on top of the upper count bits
  localparam int HI_W = CNT_W - DATA_W;

  logic [PAGE_W-1:0]        page;
  logic [ADDR_W-PAGE_W-1:0] unused_offset;
  cic_req_t                 req;
  logic [CNT_W-1:0]         cnt;
  logic                     en, reach;

  assign page          = bus_addr[ADDR_W-1 -: PAGE_W];
  assign unused_offset = bus_addr[ADDR_W-PAGE_W-1:0];

  cic_decode #(
    .PAGE_W(PAGE_W), .LO_PAGE(LO_PAGE), .HI_PAGE(HI_PAGE)
  ) u_decode (
    .cpu_ce(cpu_ce), .bus_sel(bus_sel), .bus_rnw(bus_rnw),
    .page(page), .req(req)
  );

  cic_count #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_count (
    .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .req(req), .wdata(wdata),
    .cnt(cnt), .en(en), .reach(reach)
  );

  cic_flag u_flag (
    .clk(clk), .rst(rst), .reach(reach), .ack(req.ack), .en(en), .irq(irq)
  );

  assign rdata_lo = cnt[DATA_W-1:0];
  assign rdata_hi = {en, cnt[CNT_W-1 -: HI_W]};
endmodule

// File: rtl/cic_checker.sv
module cic_checker #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 15,
  parameter int PAGE_W = 5,
  parameter logic [PAGE_W-1:0] LO_PAGE = 5'b01010,
  parameter logic [PAGE_W-1:0] HI_PAGE = 5'b01011
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ce,
  input logic              bus_sel,
  input logic              bus_rnw,
  input logic [PAGE_W-1:0] page,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata_lo,
  input logic [DATA_W-1:0] rdata_hi,
  input logic              irq
);
  localparam int HI_W = CNT_W - DATA_W;
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] count;
  logic en, acc, wr, near_top;
  assign count    = {rdata_hi[HI_W-1:0], rdata_lo};
  assign en       = rdata_hi[DATA_W-1];
  assign acc      = cpu_ce && bus_sel && (page == LO_PAGE || page == HI_PAGE);
  assign wr       = acc && !bus_rnw;
  assign near_top = (count == TOP - CNT_W'(1));

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (rdata_lo == '0 && rdata_hi == '0 && !irq));

  assert_load_lo_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_ce && bus_sel && !bus_rnw && page == LO_PAGE) |=> rdata_lo == $past(wdata));

  assert_load_hi_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_ce && bus_sel && !bus_rnw && page == HI_PAGE) |=> rdata_hi == $past(wdata));

  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (cpu_ce && en && !wr && count != TOP) |=> count == $past(count) + CNT_W'(1));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !cpu_ce |=> ($stable(rdata_lo) && $stable(rdata_hi) && $stable(irq)));

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (count == TOP && !wr) |=> count == TOP);

  assert_rise_at_top_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> count == TOP);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (acc && !(en && near_top && !wr)) |=> !irq);

  assert_idle_decode_R9: assert property (@(posedge clk) disable iff (rst)
    (cpu_ce && !acc && !en) |=> ($stable(rdata_lo) && $stable(rdata_hi) && $stable(irq)));

  assert_write_no_event_R10: assert property (@(posedge clk) disable iff (rst)
    wr |=> !irq);
endmodule

bind cyc_irq_counter cic_checker #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W),
  .LO_PAGE(LO_PAGE), .HI_PAGE(HI_PAGE)
) u_cic_checker (
  .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .bus_sel(bus_sel),
  .bus_rnw(bus_rnw), .page(page), .wdata(wdata),
  .rdata_lo(rdata_lo), .rdata_hi(rdata_hi), .irq(irq)
);

// File: tb/test_cyc_irq_counter.sv
`timescale 1ns/1ps
module test_cyc_irq_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_ce = 1'b0, bus_sel = 1'b0, bus_rnw = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata_lo, rdata_hi;
  logic        irq;

  always #4 clk = ~clk;  // 125 MHz

  cyc_irq_counter i_cyc_irq_counter (
    .clk(clk), .rst(rst), .cpu_ce(cpu_ce), .bus_sel(bus_sel),
    .bus_rnw(bus_rnw), .bus_addr(bus_addr), .wdata(wdata),
    .rdata_lo(rdata_lo), .rdata_hi(rdata_hi), .irq(irq)
  );

  int    m_cnt = 0, m_en = 0, m_pend = 0;
  int    errors = 0, checks = 0;
  bit    done = 0;
  string phase = "R1";

  // behavioural reference, applied at each rising edge
  task automatic model_step();
    int  pg;
    bit  acc, hit;
    pg  = int'(bus_addr) >> 11;
    acc = cpu_ce && bus_sel && (pg == 10 || pg == 11);
    hit = 0;
    if (rst) begin
      m_cnt = 0; m_en = 0; m_pend = 0;
    end else if (cpu_ce) begin
      if (acc && !bus_rnw) begin
        if (pg == 10) m_cnt = (m_cnt & 32'h7F00) | int'(wdata);
        else begin
          m_cnt = (m_cnt & 32'hFF) | ((int'(wdata) & 32'h7F) << 8);
          m_en  = int'(wdata) >> 7;
        end
      end else if (m_en == 1 && m_cnt < 32'h7FFF) begin
        m_cnt++;
        if (m_cnt == 32'h7FFF) hit = 1;
      end
      if (hit) m_pend = 1;
      else if (acc) m_pend = 0;
    end
  endtask

  task automatic compare();
    int exp_lo, exp_hi, exp_irq;
    exp_lo  = m_cnt & 32'hFF;
    exp_hi  = (m_en << 7) | (m_cnt >> 8);
    exp_irq = m_pend & m_en;
    checks++;
    if (int'(rdata_lo) != exp_lo || int'(rdata_hi) != exp_hi || int'(irq) != exp_irq) begin
      errors++;
      $display("FAIL %s: lo/hi/irq actual %h/%h/%0d expected %h/%h/%0d",
               phase, rdata_lo, rdata_hi, irq, exp_lo[7:0], exp_hi[7:0], exp_irq);
    end
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit ce, input bit sel, input bit rnw,
                      input logic [15:0] addr, input logic [7:0] wd);
    cpu_ce = ce; bus_sel = sel; bus_rnw = rnw; bus_addr = addr; wdata = wd;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n, input bit ce);
    for (int i = 0; i < n; i++) step(ce, 1'b0, 1'b1, 16'h0000, 8'h00);
  endtask

  task automatic wr(input logic [15:0] addr, input logic [7:0] v);
    step(1'b1, 1'b1, 1'b0, addr, v);
  endtask

  task automatic rd(input logic [15:0] addr);
    step(1'b1, 1'b1, 1'b1, addr, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    phase = "R1";
    repeat (3) step(1'b1, 1'b1, 1'b0, 16'h5800, 8'hFF);
    check_eq("R1", {rdata_hi, rdata_lo, 7'b0, irq}, 0);
    rst = 1'b0;

    phase = "R2";
    wr(16'h5000, 8'h34);
    rd(16'h57FF);
    check_eq("R2", rdata_lo, 8'h34);

    phase = "R3";
    wr(16'h5BCD, 8'h12);
    check_eq("R3", rdata_hi, 8'h12);
    idle(5, 1'b1);
    check_eq("R4 disabled hold", rdata_lo, 8'h34);

    phase = "R4";
    wr(16'h5800, 8'h92);
    idle(10, 1'b1);
    check_eq("R4", rdata_lo, 8'h3E);
    idle(6, 1'b0);
    check_eq("R4 ce low", rdata_lo, 8'h3E);

    phase = "R5";
    wr(16'h5800, 8'hFF);
    wr(16'h5000, 8'hF0);
    idle(20, 1'b1);
    check_eq("R5", {rdata_hi, rdata_lo}, 16'hFFFF);
    check_eq("R6", irq, 1);

    phase = "R9";
    rd(16'h6000);
    wr(16'h4800, 8'h00);
    step(1'b1, 1'b0, 1'b0, 16'h5000, 8'h00);
    step(1'b0, 1'b1, 1'b0, 16'h5000, 8'h00);
    check_eq("R9", {rdata_lo, 7'b0, irq}, 16'hFF01);

    phase = "R7";
    rd(16'h5000);
    check_eq("R7", irq, 0);
    idle(5, 1'b1);
    check_eq("R7 no refire", irq, 0);

    phase = "R8";
    wr(16'h5000, 8'h20);
    idle(1, 1'b1);
    wr(16'h5000, 8'h20);
    check_eq("R8", rdata_lo, 8'h20);

    phase = "R10";
    wr(16'h5000, 8'hFF);
    idle(3, 1'b1);
    check_eq("R10", irq, 0);

    phase = "R7 set wins";
    wr(16'h5000, 8'hFE);
    rd(16'h5800);
    check_eq("R7 set wins", irq, 1);

    phase = "R6";
    wr(16'h5800, 8'h80);
    wr(16'h5000, 8'h00);
    idle(32766, 1'b1);
    check_eq("R6 one short", irq, 0);
    idle(1, 1'b1);
    check_eq("R6 at top", irq, 1);

    phase = "mix R2 R3 R7 R9";
    for (int i = 0; i < 20000; i++) begin
      logic [31:0] r;
      logic [15:0] a;
      logic [7:0]  d;
      r = $urandom;
      case (r[6:5])
        2'd0: a = 16'h5000 | {5'b0, r[18:8]};
        2'd1: a = 16'h5800 | {5'b0, r[18:8]};
        2'd2: a = 16'h4800;
        default: a = 16'h6000;
      endcase
      d = r[7] ? 8'hFF : r[31:24];
      step(r[0] | r[1], r[2] & r[3], r[4] | r[19], a, d);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule